// File: doc/BRIEF.md
# Tree-Scheduled Prefix Adder

This block forms every inclusive running sum of N operands, where N is a power of two and at least 4. A start strobe loads the N parallel operands into the leaf registers of a complete binary tree of adder nodes. The tree then works through a fixed four-phase schedule, one tree level per clock:

1. An up-sweep forms pair sums, going up the tree until the two nodes under the root.
2. A leaf-pair fix puts the pair total into each right-hand leaf.
3. A sibling swap moves each internal left node's sum into its right sibling and clears the left node.
4. A down-sweep adds each node's value into both of its children, one level at a time, down to the leaves.

When the schedule ends, output slot i holds the wrapped sum of operands 0 through i, and a one-cycle done pulse is raised.

All arithmetic is modulo 2^W, with zero as the identity. A run is fixed at 2·log2(N)+2 clock cycles. Within a run, the up-sweep takes log2(N)−1 cycles, the fix and the swap take two cycles each, and the down-sweep takes log2(N)−1 cycles. Only while the unit is idle are the outputs meaningful. During a run they show intermediate leaf values.

Top module: `pfx_tree_scan`

## Requirements
- R1: While reset is low and after its release, done_o is 0 and every sum_o slot is 0.
- R2: After a run, slot i of sum_o (bits i·W+W−1 down to i·W, slot 0 at the LSBs) equals the sum of operand slots 0 to i of the op_i value sampled with the start.
- R3: All sums wrap modulo 2^W. For example, N operands of all ones give 2^W−(i+1) in slot i.
- R4: done_o is high for exactly one cycle. That cycle is the one after the clock edge that lies 2·log2(N)+2 edges after the edge that sampled the accepted start.
- R5: A start_i pulse, with any op_i value, presented while a run is in progress is ignored. The run's result and the timing of its done pulse are unchanged.
- R6: While idle with start_i low, sum_o holds its value even when op_i changes.
- R7: A start_i sampled on the edge that ends the done cycle is accepted. A new run then begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| op_i | input | N*W | Operands, slot i at bits i*W+W-1 down to i*W |
| sum_o | output | N*W | Inclusive prefix sums, same slot layout |
| done_o | output | 1 | One-cycle pulse when the sums are ready |

## Verification
The bench's behavioural model counts 2·log2(N)+2 rising edges from the edge that accepts a start. It expects done_o high in the single cycle after the last of those edges, and it expects the new sums from that cycle on. Checks are made on the falling edge. done_o is compared in every cycle. sum_o is compared only in cycles where the model is idle, so the intermediate leaf values of a run are never judged. Starts injected mid-run, and operand changes with no start, are covered by the same per-cycle comparison.

// File: rtl/pfx_pkg.sv
`timescale 1ns/1ps
package pfx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_UP,
    PH_FIX,
    PH_SWAP,
    PH_DOWN
  } pfx_phase_e;
endpackage

// File: rtl/pfx_seq.sv
`timescale 1ns/1ps
module pfx_seq import pfx_pkg::*; #(
  parameter int L  = 3,
  parameter int LW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          load_o,
  output pfx_phase_e    phase_o,
  output logic [LW-1:0] lvl_o,
  output logic          act_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int STEPS = 2 * L + 2;
  localparam int CW    = $clog2(STEPS + 1) + 1;

  pfx_phase_e    phase_q;
  logic [LW-1:0] lvl_q;
  logic          sub_q;
  logic          done_q;

  assign busy_o  = (phase_q != PH_IDLE);
  assign load_o  = start_i && !busy_o;
  assign phase_o = phase_q;
  assign lvl_o   = lvl_q;
  assign act_o   = sub_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      lvl_q   <= '0;
      sub_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_UP;
          lvl_q   <= LW'(L - 1);
        end
        PH_UP: begin
          if (lvl_q == LW'(1)) begin
            phase_q <= PH_FIX;
            sub_q   <= 1'b0;
          end else lvl_q <= lvl_q - LW'(1);
        end
        // two-cycle budget: transfer, then update
        PH_FIX: begin
          if (sub_q) begin
            phase_q <= PH_SWAP;
            sub_q   <= 1'b0;
          end else sub_q <= 1'b1;
        end
        PH_SWAP: begin
          if (sub_q) begin
            phase_q <= PH_DOWN;
            sub_q   <= 1'b0;
            lvl_q   <= LW'(2);
          end else sub_q <= 1'b1;
        end
        PH_DOWN: begin
          if (lvl_q == LW'(L)) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else lvl_q <= lvl_q + LW'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // run-length counter for checking only
  logic [CW-1:0] run_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt_q <= '0;
    else if (load_o) run_cnt_q <= '0;
    else if (busy_o) run_cnt_q <= run_cnt_q + CW'(1);
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_RUN_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> run_cnt_q == CW'(STEPS)); // R4
  AST_UP_TO_FIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_UP |=> (phase_q == PH_UP || phase_q == PH_FIX)); // R4
  AST_BUSY_KEEPS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SWAP && start_i) |=> phase_q != PH_UP); // R5
endmodule

// File: rtl/pfx_nodes.sv
`timescale 1ns/1ps
module pfx_nodes import pfx_pkg::*; #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int L  = 3,
  parameter int LW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [N*W-1:0] op_i,
  input  pfx_phase_e     phase_i,
  input  logic [LW-1:0]  lvl_i,
  input  logic           act_i,
  output logic [N*W-1:0] sum_o
);
  localparam int NODES = 2 * N;

  // heap layout: node 1 root, node k at level d when (k >> d) == 1, leaves N..2N-1
  logic [W-1:0] node_q [NODES];
  logic [W-1:0] node_d [NODES];

  always_comb begin
    node_d = node_q;
    for (int k = 2; k < N; k++) begin
      if (!load_i) begin
        case (phase_i)
          PH_UP:   if ((k >> lvl_i) == 1) node_d[k] = node_q[2*k] + node_q[2*k+1];
          PH_SWAP: if (act_i) node_d[k] = (k % 2 == 1) ? node_q[k-1] : '0;
          PH_DOWN: if ((k >> lvl_i) == 1) node_d[k] = node_q[k] + node_q[k/2];
          default: ;
        endcase
      end
    end
    for (int k = N; k < NODES; k++) begin
      if (load_i) node_d[k] = op_i[(k-N)*W +: W];
      else begin
        case (phase_i)
          PH_FIX:  if (act_i && (k % 2 == 1)) node_d[k] = node_q[k-1] + node_q[k];
          PH_DOWN: if ((k >> lvl_i) == 1) node_d[k] = node_q[k] + node_q[k/2];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NODES; k++) node_q[k] <= '0;
    end else begin
      node_q <= node_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    assign sum_o[i*W +: W] = node_q[N+i];
  end

  AST_SWAP_CLEARS_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_SWAP && act_i) |=> node_q[2] == '0); // R2
endmodule

// File: rtl/pfx_tree_scan.sv
`timescale 1ns/1ps
module pfx_tree_scan import pfx_pkg::*; #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N*W-1:0] op_i,
  output logic [N*W-1:0] sum_o,
  output logic           done_o
);
  localparam int L  = $clog2(N);
  localparam int LW = $clog2(L + 1);

  logic          load;
  pfx_phase_e    phase;
  logic [LW-1:0] lvl;
  logic          act;
  logic          busy;

  pfx_seq #(.L(L), .LW(LW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .phase_o (phase),
    .lvl_o   (lvl),
    .act_o   (act),
    .busy_o  (busy),
    .done_o  (done_o)
  );

  pfx_nodes #(.N(N), .W(W), .L(L), .LW(LW)) u_nodes (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .op_i    (op_i),
    .phase_i (phase),
    .lvl_i   (lvl),
    .act_i   (act),
    .sum_o   (sum_o)
  );

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> $stable(sum_o)); // R6
endmodule

// File: tb/pfx_tree_scan_tb_top.sv
`timescale 1ns/1ps
module pfx_tree_scan_tb_top;
  localparam int N     = 8;
  localparam int W     = 16;
  localparam int L     = $clog2(N);
  localparam int STEPS = 2 * L + 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N*W-1:0] op = '0;
  logic [N*W-1:0] sum;
  logic           done;

  int checks = 0;
  int fails  = 0;
  bit wd_hit = 1'b0;
  string tag_sum  = "R2";
  string tag_done = "R4";

  pfx_tree_scan #(.N(N), .W(W)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .op_i    (op),
    .sum_o   (sum),
    .done_o  (done)
  );

  always #2.5 clk = ~clk;

  function automatic logic [N*W-1:0] prefix_of(input logic [N*W-1:0] v);
    logic [N*W-1:0] r;
    logic [W-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      acc = acc + v[i*W +: W];
      r[i*W +: W] = acc;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int             rem = 0;
  logic           exp_done = 1'b0;
  logic [N*W-1:0] exp_sum = '0;
  logic [N*W-1:0] pend = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rem = 0; exp_done = 1'b0; exp_sum = '0;
    end else begin
      exp_done = 1'b0;
      if (rem == 0) begin
        if (start) begin
          pend = prefix_of(op);
          rem  = STEPS;
        end
      end else begin
        rem--;
        if (rem == 0) begin
          exp_done = 1'b1;
          exp_sum  = pend;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !wd_hit) begin
      chk(done === exp_done, tag_done, {{(N*W-1){1'b0}}, done}, {{(N*W-1){1'b0}}, exp_done});
      if (rem == 0) chk(sum === exp_sum, tag_sum, sum, exp_sum);
    end
  end

  task automatic kick(input logic [N*W-1:0] v);
    @(negedge clk);
    op = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic settle();
    repeat (STEPS + 3) @(negedge clk);
  endtask

  function automatic logic [N*W-1:0] pat(input int seed);
    logic [N*W-1:0] r;
    int unsigned s;
    s = seed;
    for (int i = 0; i < N; i++) begin
      s = s * 1103515245 + 12345;
      r[i*W +: W] = W'(s >> 7);
    end
    return r;
  endfunction

  initial begin
    logic [N*W-1:0] v;
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R1", {{(N*W-1){1'b0}}, done}, '0);
    chk(sum === '0, "R1", sum, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sum === '0 && done === 1'b0, "R1", sum, '0);

    // R2: counting and pseudo-random operands
    tag_sum = "R2";
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(i + 1);
    kick(v); settle();
    kick(pat(7)); settle();
    kick(pat(99)); settle();

    // R3: wrap
    tag_sum = "R3";
    kick({(N*W){1'b1}}); settle();
    chk(sum[(N-1)*W +: W] === W'(-N), "R3", sum, {{((N-1)*W){1'b0}}, W'(-N)});

    // R5: start while busy is ignored
    tag_sum = "R5"; tag_done = "R5";
    kick(pat(3));
    repeat (2) @(negedge clk);
    op = pat(4); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (STEPS) @(negedge clk);
    chk(sum === prefix_of(pat(3)), "R5", sum, prefix_of(pat(3)));
    tag_done = "R4";

    // R6: idle hold with changing operands
    tag_sum = "R6";
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      op = pat(200 + i);
    end
    @(negedge clk);
    chk(sum === prefix_of(pat(3)), "R6", sum, prefix_of(pat(3)));

    // R7: start during the done cycle
    tag_sum = "R7";
    kick(pat(11));
    do @(negedge clk); while (!done);
    op = pat(12); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    settle();
    chk(sum === prefix_of(pat(12)), "R7", sum, prefix_of(pat(12)));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    wd_hit = 1'b1;
    checks++;
    fails++;
    $display("FAIL R4 watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule